// File: doc/BRIEF.md
# Calendar Alarm Comparator with Shared Interrupt / Clock Pin

This block watches a running calendar time and raises an interrupt when that time matches one of two programmable alarm settings. The time comes in as six BCD bytes: seconds, minutes, hours, day of month, month and weekday. Each alarm holds one byte per field. Bit 7 of each alarm byte selects whether that field takes part in the comparison, and bits 6:0 carry the value to compare. No year field exists, so an alarm can fire once a minute, once an hour, once a day, and so on. The comparison is evaluated once per seconds strobe and acts on the rising edge of the match condition.

Both alarms drive a single active-low pin. In latched mode a match sets a sticky per-alarm flag, and the pin stays low until software clears that flag. In pulsed mode every match produces a low pulse of fixed length on the pin, so a repeating alarm gives one pulse for each repeat. A two-bit output select can instead hand the pin to a clock: the synchronized oscillator itself, or that oscillator divided down to a fast rate or to a one-hertz rate. While a clock is selected, the alarm indication is hidden from the pin.

Software loads the alarm bytes, the control byte and the clear strobe through a simple synchronous write port.

Top module: `rtc_alarm_irq`

## Requirements
- R1: A write with `wr_en` high stores `wr_data` in alarm k, field f, at address 6*k+f. The field order is f=0 seconds, 1 minutes, 2 hours, 3 day of month, 4 month, 5 weekday. Address 12 is the control byte. A write to address 13 is a clear strobe and stores nothing.
- R2: An alarm matches when it has at least one enable bit (bit 7) set and, for every enabled field, alarm bits 6:0 equal time bits 6:0. An alarm with no enabled fields never matches.
- R3: A match event occurs only in a cycle with `sec_tick` high, and only when the alarm matches at that strobe but did not match at the previous strobe. A time that keeps matching across strobes therefore gives a single event.
- R4: Control bit 0 enables the events of alarm 0, and control bit 1 enables those of alarm 1. The events of a disabled alarm reach neither the flags nor the pin.
- R5: With control bit 2 = 0 (latched mode), an enabled event of alarm k sets `alm_flag[k]` on the next clock edge. A write to address 13 with data bit k = 1 clears that flag. If a set and a clear reach the same flag in the same cycle, the set wins. With output select 00, the pin is low exactly while any flag is set.
- R6: With control bit 2 = 1 (pulsed mode), each enabled event drives the pin low for 2^DIV_FAST_LOG2 rising edges of the oscillator, and no flag is set.
- R7: Control bits 5:4 select what drives the pin. 00 selects the alarm indication. 01 selects the oscillator input delayed by one clock. 10 selects the oscillator divided by 2^DIV_FAST_LOG2. 11 selects the oscillator divided by 2^DIV_SLOW_LOG2. With any non-zero code, the alarm indication does not affect the pin.
- R8: A synchronous reset clears the alarm bytes, the control byte and the flags, and releases the pin high.
- R9: Both alarms share the pin: an enabled event of either alarm pulls it low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| osc_in | input | 1 | Oscillator level, synchronous to clk |
| sec_tick | input | 1 | One-cycle strobe, once per second |
| tm_sec | input | 8 | Current seconds, BCD |
| tm_min | input | 8 | Current minutes, BCD |
| tm_hour | input | 8 | Current hours, BCD |
| tm_date | input | 8 | Current day of month, BCD |
| tm_month | input | 8 | Current month, BCD |
| tm_wday | input | 8 | Current weekday, BCD |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 8 | Write data |
| irq_fout_n | output | 1 | Shared active-low interrupt / clock pin |
| alm_flag | output | 2 | Sticky latched-mode flags, one per alarm |

## Verification
The bench builds the block with DIV_FAST_LOG2=3 and DIV_SLOW_LOG2=5, and runs the oscillator at one sixth of the clock rate. With these values the fast and slow divided clocks have periods of 48 and 192 clocks, and a pulsed-mode low lasts 43 to 48 clocks. Both dividers and the pulse length can therefore be measured exactly within a short run. The small field count allows a sweep over all 64 enable masks of one alarm, each combined with a mismatch in every single field and with a full match, so that every masking case of the comparator is checked against arithmetic in the bench.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;
   localparam int NUM_ALARMS = 2;
   localparam int NUM_FIELDS = 6;
   localparam int BYTE_W     = 8;
   localparam int CTRL_OFS   = NUM_ALARMS * NUM_FIELDS;
   localparam int CLR_OFS    = CTRL_OFS + 1;

   // control byte bit positions
   localparam int CB_PULSE   = 2;
   localparam int CB_SEL_LO  = 4;

   typedef logic [NUM_FIELDS-1:0][BYTE_W-1:0] cal_t;

   typedef enum logic [1:0] {
      PIN_ALARM = 2'd0,
      PIN_PASS  = 2'd1,
      PIN_FAST  = 2'd2,
      PIN_SLOW  = 2'd3
   } pin_sel_e;
endpackage

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp
   import rtc_alarm_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic sec_tick,
   input  cal_t alarm_i,
   input  cal_t now_i,
   output logic event_o
);
   logic any_en;
   logic all_eq;
   logic match_now;
   logic match_prev_q;

   always_comb begin
      any_en = 1'b0;
      all_eq = 1'b1;
      for (int f = 0; f < NUM_FIELDS; f++) begin
         if (alarm_i[f][BYTE_W-1]) begin
            any_en = 1'b1;
            if (alarm_i[f][BYTE_W-2:0] != now_i[f][BYTE_W-2:0]) all_eq = 1'b0;
         end
      end
      match_now = any_en & all_eq;
   end

   always_ff @(posedge clk) begin
      if (rst)           match_prev_q <= 1'b0;
      else if (sec_tick) match_prev_q <= match_now;
   end

   assign event_o = sec_tick & match_now & ~match_prev_q;
endmodule

// File: rtl/rtc_alarm_clkdiv.sv
module rtc_alarm_clkdiv #(
   parameter int DIV_FAST_LOG2 = 3,
   parameter int DIV_SLOW_LOG2 = 15
) (
   input  logic clk,
   input  logic rst,
   input  logic osc_in,
   output logic osc_rise_o,
   output logic pass_o,
   output logic fast_o,
   output logic slow_o
);
   logic                     osc_q;
   logic                     osc_q2;
   logic [DIV_SLOW_LOG2-1:0] cnt_q;

   assign osc_rise_o = osc_q & ~osc_q2;

   always_ff @(posedge clk) begin
      if (rst) begin
         osc_q  <= 1'b0;
         osc_q2 <= 1'b0;
         cnt_q  <= '0;
      end else begin
         osc_q  <= osc_in;
         osc_q2 <= osc_q;
         if (osc_rise_o) cnt_q <= cnt_q + 1'b1;
      end
   end

   assign pass_o = osc_q;
   assign fast_o = cnt_q[DIV_FAST_LOG2-1];
   assign slow_o = cnt_q[DIV_SLOW_LOG2-1];
endmodule

// File: rtl/rtc_alarm_pin.sv
module rtc_alarm_pin
   import rtc_alarm_pkg::*;
#(
   parameter int DIV_FAST_LOG2 = 3
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic [NUM_ALARMS-1:0] evt_i,
   input  logic [NUM_ALARMS-1:0] int_en_i,
   input  logic                  pulse_mode_i,
   input  logic [NUM_ALARMS-1:0] clr_i,
   input  logic                  osc_rise_i,
   input  pin_sel_e              sel_i,
   input  logic                  pass_i,
   input  logic                  fast_i,
   input  logic                  slow_i,
   output logic [NUM_ALARMS-1:0] flag_o,
   output logic                  pin_n_o
);
   localparam int CNT_W = DIV_FAST_LOG2 + 1;
   localparam logic [CNT_W-1:0] PULSE_LEN = {1'b1, {DIV_FAST_LOG2{1'b0}}};

   logic [NUM_ALARMS-1:0] gated;
   logic [NUM_ALARMS-1:0] flag_q;
   logic [CNT_W-1:0]      pulse_q;
   logic                  alarm_on;

   assign gated = evt_i & int_en_i;

   always_ff @(posedge clk) begin
      if (rst) begin
         flag_q  <= '0;
         pulse_q <= '0;
      end else begin
         flag_q <= (flag_q & ~clr_i) | (pulse_mode_i ? '0 : gated);
         if (pulse_mode_i && (|gated))          pulse_q <= PULSE_LEN;
         else if (osc_rise_i && pulse_q != '0)  pulse_q <= pulse_q - 1'b1;
      end
   end

   assign alarm_on = pulse_mode_i ? (pulse_q != '0) : (|flag_q);
   assign flag_o   = flag_q;

   always_comb begin
      case (sel_i)
         PIN_ALARM: pin_n_o = ~alarm_on;
         PIN_PASS:  pin_n_o = pass_i;
         PIN_FAST:  pin_n_o = fast_i;
         default:   pin_n_o = slow_i;
      endcase
   end
endmodule

// File: rtl/rtc_alarm_irq.sv
module rtc_alarm_irq
   import rtc_alarm_pkg::*;
#(
   parameter int ADDR_W        = 4,
   parameter int DIV_FAST_LOG2 = 3,
   parameter int DIV_SLOW_LOG2 = 15
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              osc_in,
   input  logic              sec_tick,
   input  logic [7:0]        tm_sec,
   input  logic [7:0]        tm_min,
   input  logic [7:0]        tm_hour,
   input  logic [7:0]        tm_date,
   input  logic [7:0]        tm_month,
   input  logic [7:0]        tm_wday,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [7:0]        wr_data,
   output logic              irq_fout_n,
   output logic [1:0]        alm_flag
);
   localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_OFS);
   localparam logic [ADDR_W-1:0] CLR_A  = ADDR_W'(CLR_OFS);

   if (DIV_FAST_LOG2 < 1) begin : g_bad_fast
      $error("DIV_FAST_LOG2 must be at least 1");
   end
   if (DIV_SLOW_LOG2 <= DIV_FAST_LOG2) begin : g_bad_slow
      $error("DIV_SLOW_LOG2 must exceed DIV_FAST_LOG2");
   end
   if ((1 << ADDR_W) <= CLR_OFS) begin : g_bad_addr
      $error("ADDR_W too narrow for the register map");
   end

   cal_t                  alm_q [NUM_ALARMS];
   logic [BYTE_W-1:0]     ctrl_q;
   cal_t                  now_t;
   logic [NUM_ALARMS-1:0] evt;
   logic [NUM_ALARMS-1:0] clr_stb;
   logic                  osc_rise, clk_pass, clk_fast, clk_slow;

   assign now_t = {tm_wday, tm_month, tm_date, tm_hour, tm_min, tm_sec};

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int k = 0; k < NUM_ALARMS; k++) alm_q[k] <= '0;
         ctrl_q <= '0;
      end else if (wr_en) begin
         for (int k = 0; k < NUM_ALARMS; k++)
            for (int f = 0; f < NUM_FIELDS; f++)
               if (wr_addr == ADDR_W'(k * NUM_FIELDS + f)) alm_q[k][f] <= wr_data;
         if (wr_addr == CTRL_A) ctrl_q <= wr_data;
      end
   end

   assign clr_stb = (wr_en && wr_addr == CLR_A) ? wr_data[NUM_ALARMS-1:0] : '0;

   for (genvar k = 0; k < NUM_ALARMS; k++) begin : g_alarm
      rtc_alarm_cmp u_cmp (
         .clk     (clk),
         .rst     (rst),
         .sec_tick(sec_tick),
         .alarm_i (alm_q[k]),
         .now_i   (now_t),
         .event_o (evt[k])
      );
   end

   rtc_alarm_clkdiv #(
      .DIV_FAST_LOG2(DIV_FAST_LOG2),
      .DIV_SLOW_LOG2(DIV_SLOW_LOG2)
   ) u_div (
      .clk       (clk),
      .rst       (rst),
      .osc_in    (osc_in),
      .osc_rise_o(osc_rise),
      .pass_o    (clk_pass),
      .fast_o    (clk_fast),
      .slow_o    (clk_slow)
   );

   rtc_alarm_pin #(
      .DIV_FAST_LOG2(DIV_FAST_LOG2)
   ) u_pin (
      .clk         (clk),
      .rst         (rst),
      .evt_i       (evt),
      .int_en_i    (ctrl_q[NUM_ALARMS-1:0]),
      .pulse_mode_i(ctrl_q[CB_PULSE]),
      .clr_i       (clr_stb),
      .osc_rise_i  (osc_rise),
      .sel_i       (pin_sel_e'(ctrl_q[CB_SEL_LO+1:CB_SEL_LO])),
      .pass_i      (clk_pass),
      .fast_i      (clk_fast),
      .slow_i      (clk_slow),
      .flag_o      (alm_flag),
      .pin_n_o     (irq_fout_n)
   );
endmodule

// File: rtl/rtc_alarm_irq_chk.sv
module rtc_alarm_irq_chk
   import rtc_alarm_pkg::*;
#(
   parameter int ADDR_W = 4
) (
   input logic              clk,
   input logic              rst,
   input logic              osc_in,
   input logic              sec_tick,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [7:0]        wr_data,
   input logic [7:0]        ctrl_q,
   input logic              irq_fout_n,
   input logic [1:0]        alm_flag
);
   localparam logic [ADDR_W-1:0] CLR_A = ADDR_W'(CLR_OFS);

   p_release_after_reset_r8: assert property (@(posedge clk)
      rst |=> (irq_fout_n && alm_flag == 2'b00));

   p_set_needs_tick_r3: assert property (@(posedge clk) disable iff (rst)
      ((alm_flag & ~$past(alm_flag)) != 2'b00) |-> $past(sec_tick));

   p_no_flag_in_pulse_r6: assert property (@(posedge clk) disable iff (rst)
      ((alm_flag & ~$past(alm_flag)) != 2'b00) |-> !$past(ctrl_q[CB_PULSE]));

   p_enable_gate0_r4: assert property (@(posedge clk) disable iff (rst)
      (alm_flag[0] && !$past(alm_flag[0])) |-> $past(ctrl_q[0]));

   p_enable_gate1_r4: assert property (@(posedge clk) disable iff (rst)
      (alm_flag[1] && !$past(alm_flag[1])) |-> $past(ctrl_q[1]));

   p_clear_r5: assert property (@(posedge clk) disable iff (rst)
      ($past(wr_en) && $past(wr_addr) == CLR_A && $past(wr_data[0]) && !$past(sec_tick))
      |-> !alm_flag[0]);

   p_latched_low_r5: assert property (@(posedge clk) disable iff (rst)
      (ctrl_q[CB_SEL_LO+1:CB_SEL_LO] == 2'd0 && !ctrl_q[CB_PULSE] && alm_flag != 2'b00)
      |-> !irq_fout_n);

   p_pass_r7: assert property (@(posedge clk) disable iff (rst)
      (ctrl_q[CB_SEL_LO+1:CB_SEL_LO] == 2'd1) |-> (irq_fout_n == $past(osc_in)));
endmodule

bind rtc_alarm_irq rtc_alarm_irq_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .osc_in    (osc_in),
   .sec_tick  (sec_tick),
   .wr_en     (wr_en),
   .wr_addr   (wr_addr),
   .wr_data   (wr_data),
   .ctrl_q    (ctrl_q),
   .irq_fout_n(irq_fout_n),
   .alm_flag  (alm_flag)
);

// File: tb/rtc_alarm_irq_test.sv
module rtc_alarm_irq_test;
   localparam int CTRL = 12;
   localparam int CLR  = 13;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       osc = 1'b0;
   logic       sec_tick = 1'b0;
   logic [7:0] tm [6];
   logic       wr_en = 1'b0;
   logic [3:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic       irq_fout_n;
   logic [1:0] alm_flag;

   int checks = 0;
   int errs   = 0;

   // base calendar time: sec, min, hour, date, month, weekday
   logic [7:0] base [6] = '{8'h35, 8'h42, 8'h17, 8'h28, 8'h11, 8'h04};

   always #2 clk = ~clk;

   initial forever begin
      repeat (3) @(negedge clk);
      osc = ~osc;
   end

   rtc_alarm_irq #(
      .ADDR_W(4), .DIV_FAST_LOG2(3), .DIV_SLOW_LOG2(5)
   ) uut (
      .clk(clk), .rst(rst), .osc_in(osc), .sec_tick(sec_tick),
      .tm_sec(tm[0]), .tm_min(tm[1]), .tm_hour(tm[2]),
      .tm_date(tm[3]), .tm_month(tm[4]), .tm_wday(tm[5]),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .irq_fout_n(irq_fout_n), .alm_flag(alm_flag)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errs++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic chk_rng(input string req, input int act, input int lo, input int hi);
      checks++;
      if (act < lo || act > hi) begin
         errs++;
         $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
      end
   endtask

   task automatic wr(input int a, input int d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 4'(a); wr_data = 8'(d);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic tick();
      @(negedge clk) sec_tick = 1'b1;
      @(negedge clk) sec_tick = 1'b0;
   endtask

   // diff = field index to disturb, 6 = none, 7 = all fields
   task automatic set_time(input int diff);
      for (int f = 0; f < 6; f++)
         tm[f] = (diff == f || diff == 7) ? (base[f] ^ 8'h01) : base[f];
   endtask

   task automatic prog_alarm(input int k, input int mask);
      for (int f = 0; f < 6; f++)
         wr(k * 6 + f, {mask[f], base[f][6:0]});
   endtask

   // forget previous match and clear flags
   task automatic rearm();
      set_time(7);
      tick();
      wr(CLR, 3);
   endtask

   task automatic period(output int p);
      int t = 0, nrise = 0, last = 0;
      logic prev = irq_fout_n;
      p = -1;
      while (nrise < 3 && t < 3000) begin
         @(negedge clk);
         t++;
         if (!prev && irq_fout_n) begin
            nrise++;
            if (nrise == 3) p = t - last;
            last = t;
         end
         prev = irq_fout_n;
      end
   endtask

   task automatic pulse_len(output int n);
      n = 0;
      while (irq_fout_n == 1'b0 && n < 1000) begin
         n++;
         @(negedge clk);
      end
   endtask

   initial begin
      int p, n;
      set_time(6);
      repeat (3) @(negedge clk);
      chk("R8 reset pin", int'(irq_fout_n), 1);
      chk("R8 reset flags", int'(alm_flag), 0);
      rst = 1'b0;

      // R1 R2: every enable mask against every single-field mismatch
      wr(CTRL, 8'h01);
      for (int mask = 0; mask < 64; mask++) begin
         prog_alarm(0, mask);
         for (int d = 0; d <= 6; d++) begin
            int exp;
            rearm();
            set_time(d);
            tick();
            exp = (mask != 0 && !(d < 6 && mask[d])) ? 1 : 0;
            chk("R2 match flag", int'(alm_flag[0]), exp);
            chk("R1 pin", int'(!irq_fout_n), exp);
         end
      end

      // R9: alarm1 alone pulls the shared pin
      prog_alarm(0, 0);
      prog_alarm(1, 6'b000010);
      wr(CTRL, 8'h03);
      rearm(); set_time(6); tick();
      chk("R9 alarm1 flag", int'(alm_flag), 2);
      chk("R9 alarm1 pin", int'(irq_fout_n), 0);

      // R4: alarm1 disabled
      wr(CTRL, 8'h01);
      rearm(); set_time(6); tick();
      chk("R4 disabled flag", int'(alm_flag), 0);
      chk("R4 disabled pin", int'(irq_fout_n), 1);

      // R3: held match gives one event only
      wr(CTRL, 8'h03);
      rearm(); set_time(6); tick();
      chk("R3 first event", int'(alm_flag), 2);
      wr(CLR, 2);
      tick();
      chk("R3 held match no event", int'(alm_flag), 0);
      set_time(1); tick(); set_time(6); tick();
      chk("R3 re-match event", int'(alm_flag), 2);

      // R5: per-flag clear
      prog_alarm(0, 6'b000001);
      rearm(); set_time(6); tick();
      chk("R5 both flags", int'(alm_flag), 3);
      wr(CLR, 2);
      chk("R5 clear1 flags", int'(alm_flag), 1);
      chk("R5 clear1 pin", int'(irq_fout_n), 0);
      wr(CLR, 1);
      chk("R5 clear0 flags", int'(alm_flag), 0);
      chk("R5 clear0 pin", int'(irq_fout_n), 1);

      // R5: set wins over clear in same cycle
      rearm(); set_time(6);
      @(negedge clk);
      sec_tick = 1'b1; wr_en = 1'b1; wr_addr = 4'(CLR); wr_data = 8'h03;
      @(negedge clk);
      sec_tick = 1'b0; wr_en = 1'b0;
      chk("R5 set beats clear", int'(alm_flag), 3);

      // R7: clock selections hide the set flags
      wr(CTRL, 8'h13); period(p);
      chk("R7 pass period", p, 6);
      wr(CTRL, 8'h23); period(p);
      chk("R7 fast period", p, 48);
      wr(CTRL, 8'h33); period(p);
      chk("R7 slow period", p, 192);
      wr(CTRL, 8'h03);
      @(negedge clk);
      chk("R7 alarm back on pin", int'(irq_fout_n), 0);

      // R6: pulsed mode, repeated alarm
      wr(CLR, 3);
      wr(CTRL, 8'h05);
      rearm(); set_time(6); tick();
      chk("R6 pulse start", int'(irq_fout_n), 0);
      pulse_len(n);
      chk_rng("R6 pulse width", n, 43, 48);
      chk("R6 no flag", int'(alm_flag), 0);
      set_time(0); tick(); set_time(6); tick();
      chk("R6 second pulse", int'(irq_fout_n), 0);
      pulse_len(n);
      chk_rng("R6 second width", n, 43, 48);

      // R8: reset mid-run clears registers and flags
      wr(CTRL, 8'h03);
      rearm(); set_time(6); tick();
      chk("R8 pre-reset flags", int'(alm_flag), 3);
      @(negedge clk) rst = 1'b1;
      repeat (2) @(negedge clk);
      rst = 1'b0;
      chk("R8 flags cleared", int'(alm_flag), 0);
      chk("R8 pin released", int'(irq_fout_n), 1);
      wr(CTRL, 8'h03);
      set_time(7); tick(); set_time(6); tick();
      chk("R8 alarm bytes cleared", int'(alm_flag), 0);

      $display("== %0d vectors applied, %0d miscompares ==", checks, errs);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errs++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, errs);
      $finish;
   end
endmodule